// File: doc/BRIEF.md
# Privilege-Aware Interrupt Arbiter

This block chooses which pending interrupt a core should take next. It reads the current privilege mode, a global enable bit for each privilege level, a machine-to-supervisor delegation mask and a supervisor-to-user delegation mask. From these it builds an enable mask for nine sources: external, timer and software at each of the user, supervisor and machine levels. The mask is ANDed with the pending vector, and one winner is picked in a fixed architectural order.

The winner is registered, and the register drives a valid flag and a cause code. The core samples these outputs and raises a take strobe when it enters the trap. The register holds through that strobe, so the cause the core acts on stays stable into the next cycle. Trap entry, CSR writes and vectoring are handled elsewhere.

Bit layout used on every vector port: source index = 3*level + kind. The level field is user=0, supervisor=1, machine=2. The kind field is software=0, timer=1, external=2. So `pend_i[8:6]` holds machine {external, timer, software}, `pend_i[5:3]` holds supervisor and `pend_i[2:0]` holds user.

Top module: `irq_arbiter`

## Requirements
- R1: The winner is the enabled pending source with the highest index. In order of precedence: machine external, machine timer, machine software, supervisor external, supervisor timer, supervisor software, user external, user timer, user software.
- R2: The cause code is 4*kind + level code, with level codes user=0, supervisor=1, machine=3. This gives software 0/1/3, timer 4/5/7 and external 8/9/11. The cause reads 0 whenever valid is low.
- R3: With `priv_i`=2'b11 (machine), machine sources are enabled only when `glb_ie_i[2]` is set. Supervisor and user sources are masked.
- R4: With `priv_i`=2'b01 (supervisor), machine source of kind k is enabled when `m2s_deleg_i[k]` is 0. When that bit is 1, the source is enabled only if `glb_ie_i[1]` is set.
- R5: With `priv_i`=2'b01, supervisor sources are enabled only when `glb_ie_i[1]` is set, and all user sources are masked.
- R6: With `priv_i`=2'b00 (user), the machine source of kind k uses `s2u_deleg_i[3+k]` and the supervisor source of kind k uses `s2u_deleg_i[k]`. Each such source is enabled when its bit is 0. When its bit is 1, it is enabled only if `glb_ie_i[0]` is set.
- R7: With `priv_i`=2'b00, user sources are enabled only when `glb_ie_i[0]` is set.
- R8: With `priv_i`=2'b10 (reserved), every source is masked. When no source is both pending and enabled, valid is 0 after the next edge.
- R9: Outputs are registered and change one clock edge after the inputs change. An asynchronous active-low reset clears valid and cause to 0.
- R10: While `take_i` is high at a clock edge, valid and cause keep their values. Updates resume at the first edge with `take_i` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| priv_i | input | 2 | Current privilege: 00 user, 01 supervisor, 11 machine, 10 reserved |
| glb_ie_i | input | 3 | Global enables {machine, supervisor, user} |
| m2s_deleg_i | input | 3 | Machine-to-supervisor delegation, indexed by kind |
| s2u_deleg_i | input | 6 | Supervisor-to-user delegation: [5:3] machine kinds, [2:0] supervisor kinds |
| pend_i | input | 9 | Pending sources, index 3*level+kind |
| take_i | input | 1 | Trap-taken strobe from the core; freezes the result register |
| irq_valid_o | output | 1 | An interrupt is selected |
| irq_cause_o | output | 4 | Cause code of the selected interrupt |

## Verification
The clocked assertions assume that all inputs are known and steady at each rising edge once reset is released. They also assume that `take_i` is used only as a one-edge hold request, with no meaning for the selection. The bench drives every input on the falling edge and keeps all of them defined from time zero. It walks each privilege encoding, including the reserved one, with delegation bits in both states. It raises `take_i` only in the directed hold test.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int NUM_LVL  = 3;
  localparam int NUM_KIND = 3;
  localparam int NUM_SRC  = NUM_LVL * NUM_KIND;
  localparam int IDX_W    = $clog2(NUM_SRC);
  localparam int CAUSE_W  = 4;

  localparam logic [1:0] PRV_U    = 2'b00;
  localparam logic [1:0] PRV_S    = 2'b01;
  localparam logic [1:0] PRV_RSVD = 2'b10;
  localparam logic [1:0] PRV_M    = 2'b11;

  // level 0/1/2 -> code 0/1/3; cause = 4*kind + level code
  function automatic logic [CAUSE_W-1:0] idx_to_cause(input logic [IDX_W-1:0] idx);
    int lvl, kind;
    lvl  = int'(idx) / NUM_KIND;
    kind = int'(idx) % NUM_KIND;
    return CAUSE_W'(kind * 4 + ((lvl == 2) ? 3 : lvl));
  endfunction
endpackage

// File: rtl/irq_mask_gen.sv
module irq_mask_gen
  import irq_arb_pkg::*;
(
  input  logic [1:0]              priv_i,
  input  logic [NUM_LVL-1:0]      glb_ie_i,
  input  logic [NUM_KIND-1:0]     m2s_deleg_i,
  input  logic [2*NUM_KIND-1:0]   s2u_deleg_i,
  output logic [NUM_SRC-1:0]      mask_o
);
  logic ie_u, ie_s, ie_m;
  assign ie_u = glb_ie_i[0];
  assign ie_s = glb_ie_i[1];
  assign ie_m = glb_ie_i[2];

  for (genvar k = 0; k < NUM_KIND; k++) begin : g_kind
    always_comb begin
      mask_o[k]              = 1'b0;
      mask_o[NUM_KIND+k]     = 1'b0;
      mask_o[2*NUM_KIND+k]   = 1'b0;
      unique case (priv_i)
        PRV_M: mask_o[2*NUM_KIND+k] = ie_m;
        PRV_S: begin
          mask_o[2*NUM_KIND+k] = ~m2s_deleg_i[k] | ie_s;
          mask_o[NUM_KIND+k]   = ie_s;
        end
        PRV_U: begin
          mask_o[2*NUM_KIND+k] = ~s2u_deleg_i[NUM_KIND+k] | ie_u;
          mask_o[NUM_KIND+k]   = ~s2u_deleg_i[k] | ie_u;
          mask_o[k]            = ie_u;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    if (priv_i == PRV_M)
      AST_M_ONLY_MACHINE: assert (mask_o[2*NUM_KIND-1:0] == '0); // R3
    if (priv_i == PRV_S)
      AST_S_USER_OFF: assert (mask_o[NUM_KIND-1:0] == '0); // R5
    if (priv_i == PRV_RSVD)
      AST_RSVD_ALL_OFF: assert (mask_o == '0); // R8
  end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
  import irq_arb_pkg::*;
#(
  parameter int N = NUM_SRC,
  localparam int W = $clog2(N)
) (
  input  logic [N-1:0] req_i,
  output logic         hit_o,
  output logic [W-1:0] idx_o
);
  // index layout makes architectural order equal to descending index
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i]) begin
        hit_o = 1'b1;
        idx_o = W'(i);
      end
    end
  end

  always_comb begin
    if (hit_o)
      AST_PICK_HIGHEST: assert ((req_i >> idx_o) == N'(1)); // R1
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_arb_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [1:0]          priv_i,
  input  logic [2:0]          glb_ie_i,
  input  logic [2:0]          m2s_deleg_i,
  input  logic [5:0]          s2u_deleg_i,
  input  logic [8:0]          pend_i,
  input  logic                take_i,
  output logic                irq_valid_o,
  output logic [CAUSE_W-1:0]  irq_cause_o
);
  logic [NUM_SRC-1:0] mask, eff;
  logic               hit;
  logic [IDX_W-1:0]   win_idx;
  logic [CAUSE_W-1:0] cause_d;

  irq_mask_gen u_mask (
    .priv_i      (priv_i),
    .glb_ie_i    (glb_ie_i),
    .m2s_deleg_i (m2s_deleg_i),
    .s2u_deleg_i (s2u_deleg_i),
    .mask_o      (mask)
  );

  assign eff = pend_i & mask;

  irq_prio_pick #(.N(NUM_SRC)) u_pick (
    .req_i (eff),
    .hit_o (hit),
    .idx_o (win_idx)
  );

  assign cause_d = hit ? idx_to_cause(win_idx) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_valid_o <= 1'b0;
      irq_cause_o <= '0;
    end else if (!take_i) begin
      irq_valid_o <= hit;
      irq_cause_o <= cause_d;
    end
  end

  AST_TAKE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |=> ($stable(irq_valid_o) && $stable(irq_cause_o))); // R10
  AST_IDLE_NO_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!take_i && !(|(pend_i & mask))) |=> !irq_valid_o); // R8
  AST_CAUSE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_valid_o |-> (irq_cause_o[1:0] != 2'b10 && irq_cause_o <= CAUSE_W'(11))); // R2
  AST_CAUSE_ZERO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_valid_o |-> (irq_cause_o == '0)); // R2
endmodule

// File: tb/tb_irq_arbiter.sv
`timescale 1ns/1ps
module tb_irq_arbiter;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] priv_i = 2'b11;
  logic [2:0] glb_ie_i = '0;
  logic [2:0] m2s_deleg_i = '0;
  logic [5:0] s2u_deleg_i = '0;
  logic [8:0] pend_i = '0;
  logic       take_i = 1'b0;
  logic       irq_valid_o;
  logic [3:0] irq_cause_o;

  int checks = 0;
  int failures = 0;

  always #10 clk_i = ~clk_i;

  irq_arbiter dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .priv_i(priv_i), .glb_ie_i(glb_ie_i),
    .m2s_deleg_i(m2s_deleg_i), .s2u_deleg_i(s2u_deleg_i), .pend_i(pend_i),
    .take_i(take_i), .irq_valid_o(irq_valid_o), .irq_cause_o(irq_cause_o)
  );

  // {priv, ie{m,s,u}, m2s, s2u, pend, exp_valid, exp_cause}
  localparam int NV = 24;
  localparam logic [27:0] VEC [NV] = '{
    {2'b11, 3'b100, 3'b000, 6'b000000, 9'b111111111, 1'b1, 4'd11}, // R1 R3
    {2'b11, 3'b100, 3'b000, 6'b000000, 9'b011000000, 1'b1, 4'd7},  // R2
    {2'b11, 3'b100, 3'b000, 6'b000000, 9'b001000000, 1'b1, 4'd3},  // R2
    {2'b11, 3'b011, 3'b000, 6'b000000, 9'b111111111, 1'b0, 4'd0},  // R3
    {2'b11, 3'b100, 3'b000, 6'b000000, 9'b000111111, 1'b0, 4'd0},  // R3
    {2'b01, 3'b000, 3'b000, 6'b000000, 9'b111000000, 1'b1, 4'd11}, // R4
    {2'b01, 3'b000, 3'b100, 6'b000000, 9'b110000000, 1'b1, 4'd7},  // R4
    {2'b01, 3'b000, 3'b111, 6'b000000, 9'b111111111, 1'b0, 4'd0},  // R4 R5
    {2'b01, 3'b010, 3'b111, 6'b000000, 9'b111000000, 1'b1, 4'd11}, // R4
    {2'b01, 3'b010, 3'b000, 6'b000000, 9'b000011000, 1'b1, 4'd5},  // R5
    {2'b01, 3'b010, 3'b000, 6'b000000, 9'b000001000, 1'b1, 4'd1},  // R5
    {2'b01, 3'b010, 3'b000, 6'b000000, 9'b000100000, 1'b1, 4'd9},  // R5
    {2'b01, 3'b111, 3'b000, 6'b000000, 9'b000000111, 1'b0, 4'd0},  // R5
    {2'b00, 3'b000, 3'b000, 6'b000000, 9'b000100000, 1'b1, 4'd9},  // R6
    {2'b00, 3'b000, 3'b000, 6'b000111, 9'b000111111, 1'b0, 4'd0},  // R6
    {2'b00, 3'b001, 3'b000, 6'b000111, 9'b000010111, 1'b1, 4'd5},  // R6
    {2'b00, 3'b001, 3'b000, 6'b000000, 9'b000000110, 1'b1, 4'd8},  // R7
    {2'b00, 3'b001, 3'b000, 6'b000000, 9'b000000010, 1'b1, 4'd4},  // R7
    {2'b00, 3'b001, 3'b000, 6'b000000, 9'b000000001, 1'b1, 4'd0},  // R7
    {2'b00, 3'b110, 3'b000, 6'b000000, 9'b000000111, 1'b0, 4'd0},  // R7
    {2'b00, 3'b000, 3'b000, 6'b100000, 9'b110000000, 1'b1, 4'd7},  // R6
    {2'b10, 3'b111, 3'b000, 6'b000000, 9'b111111111, 1'b0, 4'd0},  // R8
    {2'b11, 3'b100, 3'b000, 6'b000000, 9'b000000000, 1'b0, 4'd0},  // R8
    {2'b01, 3'b010, 3'b000, 6'b000000, 9'b001100000, 1'b1, 4'd3}   // R1
  };

  task automatic check(input string tag, input logic ev, input logic [3:0] ec);
    checks++;
    if (irq_valid_o !== ev || irq_cause_o !== ec) begin
      failures++;
      $display("FAIL %s: valid=%0b cause=%0d expected valid=%0b cause=%0d",
               tag, irq_valid_o, irq_cause_o, ev, ec);
    end
  endtask

  task automatic drive(input logic [1:0] p, input logic [2:0] ie, input logic [2:0] md,
                       input logic [5:0] sd, input logic [8:0] pd);
    priv_i = p; glb_ie_i = ie; m2s_deleg_i = md; s2u_deleg_i = sd; pend_i = pd;
  endtask

  initial begin
    repeat (10000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R9: reset state with a live winner on the inputs
    drive(2'b11, 3'b100, 3'b000, 6'b0, 9'b111111111);
    repeat (3) @(negedge clk_i);
    check("R9 reset", 1'b0, 4'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R9 after release", 1'b1, 4'd11);

    for (int i = 0; i < NV; i++) begin
      logic [1:0] p; logic [2:0] ie, md; logic [5:0] sd; logic [8:0] pd;
      logic ev; logic [3:0] ec;
      {p, ie, md, sd, pd, ev, ec} = VEC[i];
      drive(p, ie, md, sd, pd);
      @(negedge clk_i);
      check($sformatf("table[%0d] R1 R2 R3 R4 R5 R6 R7 R8", i), ev, ec);
    end

    // R9: one edge of latency
    drive(2'b11, 3'b100, 3'b000, 6'b0, 9'b000000000);
    @(negedge clk_i);
    check("R9 idle", 1'b0, 4'd0);
    drive(2'b11, 3'b100, 3'b000, 6'b0, 9'b010000000);
    @(posedge clk_i); #2;
    check("R9 latency", 1'b1, 4'd7);

    // R10: take strobe holds the result
    @(negedge clk_i);
    drive(2'b01, 3'b010, 3'b000, 6'b0, 9'b000000001); // user masked -> would clear
    take_i = 1'b1;
    @(negedge clk_i);
    check("R10 hold on take", 1'b1, 4'd7);
    drive(2'b01, 3'b010, 3'b000, 6'b0, 9'b000100000);
    @(negedge clk_i);
    check("R10 still held", 1'b1, 4'd7);
    take_i = 1'b0;
    @(negedge clk_i);
    check("R10 resume", 1'b1, 4'd9);

    // R8: reserved mode masks every source
    drive(2'b10, 3'b111, 3'b111, 6'b111111, 9'b111111111);
    @(negedge clk_i);
    check("R8 reserved", 1'b0, 4'd0);

    // R2 R1: supervisor software wins over all user sources in user mode
    drive(2'b00, 3'b001, 3'b000, 6'b0, 9'b000001111);
    @(negedge clk_i);
    check("R2 ssw code", 1'b1, 4'd1);

    // R9: asynchronous reset mid-run
    drive(2'b11, 3'b100, 3'b000, 6'b0, 9'b100000000);
    @(negedge clk_i);
    check("R9 pre-reset", 1'b1, 4'd11);
    #3 rst_ni = 1'b0;
    #1;
    check("R9 async clear", 1'b0, 4'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R9 recover", 1'b1, 4'd11);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule